// File: doc/BRIEF.md
# CPU Interrupt Pending and Mask Unit

This block sits between sixteen interrupt request lines and the CPU core. Each line is watched for a low-to-high transition, and every transition latches a pending bit in a 16-bit pending register. A second 16-bit register holds one mask bit per line. A line requests service only when its pending bit and its mask bit are both 1. The block drives a single request to the core together with the 4-bit index of the line that should be serviced first.

Software reaches both registers through one plain register port. A select input picks the register, a write strobe loads the whole 16-bit word, and the read data shows the selected register in the same cycle. Software sets or clears single bits by read-modify-write, for example OR-ing in 0x0008 or AND-ing with 0xFFF7 for the line at bit 3. When the core takes an interrupt, it pulses the acknowledge input with that line's index, and the block clears that one pending bit.

No data stream passes through this block, so no port uses a valid/ready handshake. The acknowledge is a one-cycle pulse and is never back-pressured. The request and index are level outputs that the core may sample in any cycle.

Top module: `intr_pend_ctl`

## Requirements
- R1: Reset clears the pending and mask registers to 0x0000. While reset is held, `cpu_req` is 0, `cpu_vec` is 0 and `reg_rdata` is 0 for either select value.
- R2: A 0-to-1 transition on `irq_line[k]` sets pending bit k at the first clock edge that samples the line high. A line held high sets its bit only once. After the bit is cleared, it stays clear until the line falls and rises again.
- R3: With `reg_we`=1, the register chosen by `reg_sel` is replaced by `reg_wdata` at the clock edge. `reg_sel`=0 selects the pending register and `reg_sel`=1 selects the mask register.
- R4: If a software write to the pending register and a new transition on line k fall in the same cycle, pending bit k ends up 1 whatever the written value.
- R5: `ack_valid`=1 with index `ack_idx`=k clears pending bit k at the clock edge. No other pending bit changes.
- R6: If an acknowledge for index k and a new transition on line k fall in the same cycle, pending bit k stays 1.
- R7: `cpu_req` is 1 exactly when some bit is 1 in both the pending and the mask register. A bit that is pending but masked raises no request and stays pending.
- R8: `cpu_vec` is the lowest bit index that is set in both registers, so bit 0 has the highest priority and bit 15 the lowest. Bits 0 to 13 are general lines, bit 14 is the data-logging line and bit 15 is the real-time OS line. `cpu_vec` is 0 when `cpu_req` is 0.
- R9: `reg_rdata` shows the register chosen by `reg_sel` combinationally, with no cycle of latency.
- R10: If a write to the pending register and an acknowledge fall in the same cycle, the written word is applied first and the acknowledged bit is then cleared from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_line | input | 16 | Interrupt request lines, rising-edge detected |
| reg_sel | input | 1 | Register select: 0 pending, 1 mask |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Selected register, combinational |
| ack_valid | input | 1 | Acknowledge pulse from the CPU |
| ack_idx | input | 4 | Index of the pending bit to clear |
| cpu_req | output | 1 | Request to the CPU |
| cpu_vec | output | 4 | Index of the line to service |

## Verification
The bench holds a line high across several cycles and then clears its bit. A design that sampled levels instead of edges would set the bit again at once. The bench also places a new edge in the same cycle as a clearing software write, and in the same cycle as an acknowledge. A design that gave software or the acknowledge precedence would lose the new event. It sets several pending bits under different masks, so a wrong priority order shows up as a wrong `cpu_vec`, and a missing mask shows up as a request for a masked bit. A combined write and acknowledge checks that the acknowledged bit is removed from the written word rather than restored by it.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned LINE_CNT = 16;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/intr_edge_det.sv
module intr_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/intr_pend_reg.sv
module intr_pend_reg #(
  parameter int unsigned W     = 16,
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     rise_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [W-1:0]     pend_o
);
  logic [W-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = wr_i ? wdata_i : pend_q;
    if (ack_i && (int'(ack_idx_i) < int'(W))) pend_d[ack_idx_i] = 1'b0;
    pend_d = pend_d | rise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R2 R4 R6
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !rise_i[ack_idx_i]) |=> !pend_q[$past(ack_idx_i)]);

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !ack_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int unsigned W     = 16,
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     act_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = int'(W) - 1; k >= 0; k--) begin
      if (act_i[k]) idx_o = IDX_W'(k);
    end
  end

  assign req_o = |act_i;

  // R8
  idx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> act_i[idx_o]);

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ((act_i & ~({W{1'b1}} << idx_o)) == '0));

  // R8
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (idx_o == '0));
endmodule

// File: rtl/intr_pend_ctl.sv
module intr_pend_ctl #(
  parameter int unsigned NUM_LINES = intr_pkg::LINE_CNT,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_line,
  input  logic                 reg_sel,
  input  logic                 reg_we,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  output logic                 cpu_req,
  output logic [IDX_W-1:0]     cpu_vec
);
  import intr_pkg::*;

  reg_sel_e            sel;
  logic [NUM_LINES-1:0] rise, pend, mask_q, active;

  assign sel = reg_sel_e'(reg_sel);

  intr_edge_det #(.W(NUM_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(irq_line), .rise_o(rise)
  );

  intr_pend_reg #(.W(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .wr_i(reg_we && (sel == SEL_PEND)), .wdata_i(reg_wdata),
    .ack_i(ack_valid), .ack_idx_i(ack_idx), .pend_o(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mask_q <= '0;
    else if (reg_we && sel == SEL_MASK)  mask_q <= reg_wdata;
  end

  assign active    = pend & mask_q;
  assign reg_rdata = (sel == SEL_MASK) ? mask_q : pend;

  intr_prio_enc #(.W(NUM_LINES)) u_prio (
    .clk(clk), .rst_n(rst_n), .act_i(active), .req_o(cpu_req), .idx_o(cpu_vec)
  );

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel) |=> (mask_q == $past(reg_wdata)));

  // R7
  req_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (mask_q[cpu_vec] && pend[cpu_vec]));
endmodule

// File: tb/tb_intr_pend_ctl.sv
`timescale 1ns/1ps
module tb_intr_pend_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_line = '0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_idx = '0;
  logic        cpu_req;
  logic [3:0]  cpu_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intr_pend_ctl dut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .cpu_req(cpu_req), .cpu_vec(cpu_vec)
  );

  typedef struct packed {
    logic [15:0] irq;
    logic        sel;
    logic        we;
    logic [15:0] wd;
    logic        av;
    logic [3:0]  ai;
    logic [15:0] ep;
    logic [15:0] em;
    logic        er;
    logic [3:0]  ev;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    {16'h0008, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd0,  16'h0008, 16'h0000, 1'b0, 4'd0,  4'd2},  // R2 edge sets
    {16'h0008, 1'b1, 1'b1, 16'h0008, 1'b0, 4'd0,  16'h0008, 16'h0008, 1'b1, 4'd3,  4'd3},  // R3 mask write
    {16'h0008, 1'b0, 1'b1, 16'h0009, 1'b0, 4'd0,  16'h0009, 16'h0008, 1'b1, 4'd3,  4'd7},  // R7 masked bit 0
    {16'h0008, 1'b1, 1'b1, 16'h0009, 1'b0, 4'd0,  16'h0009, 16'h0009, 1'b1, 4'd0,  4'd8},  // R8 bit 0 first
    {16'h0008, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd0,  16'h0008, 16'h0009, 1'b1, 4'd3,  4'd5},  // R5 ack 0
    {16'h0008, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd3,  16'h0000, 16'h0009, 1'b0, 4'd0,  4'd2},  // R2 held, no reset
    {16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd0,  16'h0000, 16'h0009, 1'b0, 4'd0,  4'd2},  // R2 fall
    {16'hC000, 1'b1, 1'b1, 16'hC000, 1'b0, 4'd0,  16'hC000, 16'hC000, 1'b1, 4'd14, 4'd8},  // R8 14 before 15
    {16'hC000, 1'b0, 1'b1, 16'h0000, 1'b0, 4'd0,  16'h0000, 16'hC000, 1'b0, 4'd0,  4'd3},  // R3 clear by write
    {16'hC002, 1'b0, 1'b1, 16'h0000, 1'b0, 4'd0,  16'h0002, 16'hC000, 1'b0, 4'd0,  4'd4},  // R4 edge beats write
    {16'hC002, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd1,  16'h0000, 16'hC000, 1'b0, 4'd0,  4'd5},  // R5 ack 1
    {16'h4002, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd0,  16'h0000, 16'hC000, 1'b0, 4'd0,  4'd2},  // R2 fall of 15
    {16'hC002, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd0,  16'h8000, 16'hC000, 1'b1, 4'd15, 4'd8},  // R8 line 15
    {16'hC002, 1'b1, 1'b1, 16'hFFFF, 1'b0, 4'd0,  16'h8000, 16'hFFFF, 1'b1, 4'd15, 4'd3},  // R3 unmask all
    {16'hC00A, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd0,  16'h8008, 16'hFFFF, 1'b1, 4'd3,  4'd8},  // R8 3 before 15
    {16'hC002, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd3,  16'h8000, 16'hFFFF, 1'b1, 4'd15, 4'd5},  // R5 ack 3
    {16'hC00A, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd3,  16'h8008, 16'hFFFF, 1'b1, 4'd3,  4'd6},  // R6 edge beats ack
    {16'hC00A, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd15, 16'h0008, 16'hFFFF, 1'b1, 4'd3,  4'd5},  // R5 ack 15 only
    {16'hC00A, 1'b0, 1'b1, 16'h0030, 1'b1, 4'd4,  16'h0020, 16'hFFFF, 1'b1, 4'd5,  4'd10}  // R10 write then ack
  };

  task automatic chk(input int rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // R9: read both registers through the combinational read port in the low phase
  task automatic observe(input int rq, input logic [15:0] ep, input logic [15:0] em,
                         input logic er, input logic [3:0] ev);
    reg_we = 1'b0; ack_valid = 1'b0;
    reg_sel = 1'b0; #0.4;
    chk(rq, "pending", reg_rdata, ep);
    chk(rq, "req", {15'd0, cpu_req}, {15'd0, er});
    chk(rq, "vec", {12'd0, cpu_vec}, {12'd0, ev});
    reg_sel = 1'b1; #0.4;
    chk(rq, "mask", reg_rdata, em);
  endtask

  task automatic step(input vec_t v);
    irq_line = v.irq; reg_sel = v.sel; reg_we = v.we; reg_wdata = v.wd;
    ack_valid = v.av; ack_idx = v.ai;
    @(posedge clk);
    @(negedge clk);
    observe(int'(v.rq), v.ep, v.em, v.er, v.ev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while held in reset
    observe(1, 16'h0000, 16'h0000, 1'b0, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    observe(1, 16'h0000, 16'h0000, 1'b0, 4'd0);

    for (int i = 0; i < NV; i++) step(TBL[i]);

    // R1: reset in mid-run clears a busy state
    rst_n = 1'b0; #0.4;
    observe(1, 16'h0000, 16'h0000, 1'b0, 4'd0);
    irq_line = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    observe(1, 16'h0000, 16'h0000, 1'b0, 4'd0);

    // R7: line 6 pending while masked, then unmasked
    step('{irq:16'h0040, sel:1'b0, we:1'b0, wd:16'h0, av:1'b0, ai:4'd0,
           ep:16'h0040, em:16'h0000, er:1'b0, ev:4'd0, rq:4'd7});
    step('{irq:16'h0040, sel:1'b1, we:1'b1, wd:16'h0040, av:1'b0, ai:4'd0,
           ep:16'h0040, em:16'h0040, er:1'b1, ev:4'd6, rq:4'd7});
    // R9: read data follows select with no clock edge in between
    reg_sel = 1'b0; #0.4;
    chk(9, "read pend", reg_rdata, 16'h0040);
    reg_sel = 1'b1; #0.4;
    chk(9, "read mask", reg_rdata, 16'h0040);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule